// File: doc/BRIEF.md
# Non-Maskable Interrupt Entry Sequencer

This block turns falling edges on an active-low non-maskable interrupt pin into a complete interrupt entry. A falling edge sets a pending flag. The flag waits until the core signals, with a one-cycle strobe, that the current instruction has finished. On that strobe the sequencer captures the core's program counter, status byte, stack pointer and mode flag. It then issues five consecutive bus cycles: three stack writes followed by two vector reads.

The three pushes store the program counter high byte, the program counter low byte and then the status byte. Each push writes at the current stack pointer, which then moves down by one. The two vector reads fetch the handler address low byte first, then the high byte. The vector location is one of two fixed addresses, selected by the emulation/native mode flag captured at the start of entry. When the last read completes, the block pulses `done` for one cycle. In that cycle it presents the new program counter and the final stack pointer to the core.

The bus is a fixed single-cycle interface with no wait states. A write is committed in every cycle in which `bus_req` and `bus_we` are both high. In a read cycle, read data is returned on `bus_rdata` in the same cycle and is sampled at the closing clock edge.

Top module: `nmi_entry_seq`

## Requirements
- R1: A high-to-low change of `nmi_n` between two consecutive clock samples sets a pending request. While a request is pending and the sequencer is idle, an `insn_done` pulse starts the entry sequence at that clock edge.
- R2: Holding `nmi_n` low after a falling edge creates no further requests, however many `insn_done` pulses follow.
- R3: The sequence never starts without `insn_done` high at a clock edge while idle. A falling edge that arrives during a running sequence stays pending, and its sequence starts on the first `insn_done` after the current one ends.
- R4: The first three bus cycles are writes (`bus_we`=1). Their data is, in order, pc_in[15:8], pc_in[7:0] and status_in, all captured at the start edge. Their addresses are SP, SP-1 and SP-2, where SP is sp_in captured at the start edge. The arithmetic wraps modulo 2^16 and the address bits above bit 15 are zero.
- R5: Bus cycles four and five are reads (`bus_we`=0). With the captured mode flag at 1 (emulation), they read 0x00FFFA and then 0x00FFFB. With the flag at 0 (native), they read 0x00FFEA and then 0x00FFEB.
- R6: `done` is high for exactly one cycle, the cycle after the fifth bus cycle. In that cycle, `new_pc` equals {second read byte, first read byte} and `sp_out` equals SP-3 modulo 2^16.
- R7: A synchronous reset returns the sequencer to idle with `bus_req`, `busy` and `done` low, and clears any pending request.
- R8: A single-cycle low pulse on `nmi_n` that is sampled by one clock edge counts as a falling edge.
- R9: `busy` and `bus_req` are high for exactly the five consecutive entry bus cycles and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nmi_n | input | 1 | Active-low non-maskable interrupt pin |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| pc_in | input | 16 | Core program counter |
| status_in | input | 8 | Core status byte |
| sp_in | input | 16 | Core stack pointer |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler address fetched from the vector |
| sp_out | output | 16 | Stack pointer after the three pushes |

## Verification
The bench targets the following corner cases:
- An edge that lands during a running entry must survive the pending-clear at the start edge. A design that lets the clear win would silently drop that interrupt.
- A pin held low must not re-trigger. A level-sensitive design would loop through entry on every boundary strobe.
- A stack pointer near zero checks wrap-around. A design that extends the subtraction would place pushes in the wrong bank or report a wrong final pointer.
- Changing the core inputs and the mode flag after the start edge checks capture. A design that reads them live would push corrupted bytes or fetch the wrong vector.
- Single-cycle glitches on the pin must still register as edges.
- Reset must clear a pending request, so that no stray entry follows it.

// File: rtl/nmi_entry_pkg.sv
package nmi_entry_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PCH  = 3'd1,
      ST_PCL  = 3'd2,
      ST_PSR  = 3'd3,
      ST_VLO  = 3'd4,
      ST_VHI  = 3'd5
   } seq_state_e;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
   parameter int IN_REG = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic nmi_n,
   input  logic take,
   output logic pending
);
   logic cur_s;
   logic prev_s;
   logic fall;

   generate
      if (IN_REG != 0) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) cur_s <= 1'b1;
            else     cur_s <= nmi_n;
         end
      end else begin : g_direct
         assign cur_s = nmi_n;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) prev_s <= 1'b1;
      else     prev_s <= cur_s;
   end

   assign fall = prev_s & ~cur_s;

   always_ff @(posedge clk) begin
      if (rst)       pending <= 1'b0;
      else if (fall) pending <= 1'b1;
      else if (take) pending <= 1'b0;
   end
endmodule

// File: rtl/nmi_vec_sel.sv
module nmi_vec_sel #(
   parameter int          ADDR_W  = 24,
   parameter logic [23:0] VEC_EMU = 24'h00FFFA,
   parameter logic [23:0] VEC_NAT = 24'h00FFEA
) (
   input  logic              emu,
   input  logic              hi_byte,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] BASE_E = ADDR_W'(VEC_EMU);
   localparam logic [ADDR_W-1:0] BASE_N = ADDR_W'(VEC_NAT);

   always_comb begin
      addr    = emu ? BASE_E : BASE_N;
      addr[0] = hi_byte;
   end
endmodule

// File: rtl/nmi_seq_fsm.sv
module nmi_seq_fsm
   import nmi_entry_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 8,
   parameter int SP_W   = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                pending,
   input  logic                insn_done,
   input  logic                emu_mode,
   input  logic [2*DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0]   status_in,
   input  logic [SP_W-1:0]     sp_in,
   input  logic [DATA_W-1:0]   bus_rdata,
   input  logic [ADDR_W-1:0]   vec_addr,
   output logic                take,
   output logic                emu_cap,
   output logic                vec_hi,
   output logic                bus_req,
   output logic                bus_we,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W-1:0]   bus_wdata,
   output logic                done,
   output logic [2*DATA_W-1:0] new_pc,
   output logic [SP_W-1:0]     sp_out
);
   localparam int PC_W = 2 * DATA_W;

   seq_state_e          st;
   logic [PC_W-1:0]     pc_c;
   logic [DATA_W-1:0]   ps_c;
   logic [DATA_W-1:0]   lo_c;
   logic [SP_W-1:0]     sp_w;

   assign take = (st == ST_IDLE) && pending && insn_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         done    <= 1'b0;
         pc_c    <= '0;
         ps_c    <= '0;
         lo_c    <= '0;
         sp_w    <= '0;
         emu_cap <= 1'b0;
         new_pc  <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (take) begin
               pc_c    <= pc_in;
               ps_c    <= status_in;
               sp_w    <= sp_in;
               emu_cap <= emu_mode;
               st      <= ST_PCH;
            end
            ST_PCH: begin sp_w <= sp_w - 1'b1; st <= ST_PCL; end
            ST_PCL: begin sp_w <= sp_w - 1'b1; st <= ST_PSR; end
            ST_PSR: begin sp_w <= sp_w - 1'b1; st <= ST_VLO; end
            ST_VLO: begin lo_c <= bus_rdata;   st <= ST_VHI; end
            ST_VHI: begin
               new_pc <= {bus_rdata, lo_c};
               done   <= 1'b1;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sp_out = sp_w;
   assign vec_hi = (st == ST_VHI);

   always_comb begin
      bus_req   = (st != ST_IDLE);
      bus_we    = (st == ST_PCH) || (st == ST_PCL) || (st == ST_PSR);
      bus_wdata = '0;
      bus_addr  = bus_we ? ADDR_W'(sp_w) : (bus_req ? vec_addr : '0);
      case (st)
         ST_PCH:  bus_wdata = pc_c[PC_W-1:DATA_W];
         ST_PCL:  bus_wdata = pc_c[DATA_W-1:0];
         ST_PSR:  bus_wdata = ps_c;
         default: bus_wdata = '0;
      endcase
   end
endmodule

// File: rtl/nmi_entry_seq.sv
module nmi_entry_seq #(
   parameter int          ADDR_W  = 24,
   parameter int          DATA_W  = 8,
   parameter int          SP_W    = 16,
   parameter int          IN_REG  = 0,
   parameter logic [23:0] VEC_EMU = 24'h00FFFA,
   parameter logic [23:0] VEC_NAT = 24'h00FFEA
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                nmi_n,
   input  logic                emu_mode,
   input  logic                insn_done,
   input  logic [2*DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0]   status_in,
   input  logic [SP_W-1:0]     sp_in,
   input  logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_req,
   output logic                bus_we,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W-1:0]   bus_wdata,
   output logic                busy,
   output logic                done,
   output logic [2*DATA_W-1:0] new_pc,
   output logic [SP_W-1:0]     sp_out
);
   generate
      if (ADDR_W < SP_W || ADDR_W < 16) begin : g_bad_addr
         $error("nmi_entry_seq: ADDR_W must cover the stack pointer and vectors");
      end
      if (VEC_EMU[0] != 1'b0 || VEC_NAT[0] != 1'b0) begin : g_bad_vec
         $error("nmi_entry_seq: vector bases must be even");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("nmi_entry_seq: DATA_W must be positive");
      end
   endgenerate

   logic              pending;
   logic              take;
   logic              emu_cap;
   logic              vec_hi;
   logic [ADDR_W-1:0] vec_addr;

   nmi_edge_latch #(.IN_REG(IN_REG)) u_edge (
      .clk(clk), .rst(rst), .nmi_n(nmi_n), .take(take), .pending(pending)
   );

   nmi_vec_sel #(.ADDR_W(ADDR_W), .VEC_EMU(VEC_EMU), .VEC_NAT(VEC_NAT)) u_vec (
      .emu(emu_cap), .hi_byte(vec_hi), .addr(vec_addr)
   );

   nmi_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_fsm (
      .clk(clk), .rst(rst), .pending(pending), .insn_done(insn_done),
      .emu_mode(emu_mode), .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in),
      .bus_rdata(bus_rdata), .vec_addr(vec_addr), .take(take), .emu_cap(emu_cap),
      .vec_hi(vec_hi), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .done(done), .new_pc(new_pc), .sp_out(sp_out)
   );

   assign busy = bus_req;
endmodule

// File: rtl/nmi_entry_chk.sv
module nmi_entry_chk #(
   parameter int          ADDR_W  = 24,
   parameter int          DATA_W  = 8,
   parameter int          SP_W    = 16,
   parameter logic [23:0] VEC_EMU = 24'h00FFFA,
   parameter logic [23:0] VEC_NAT = 24'h00FFEA
) (
   input logic                clk,
   input logic                rst,
   input logic                insn_done,
   input logic [2*DATA_W-1:0] pc_in,
   input logic [SP_W-1:0]     sp_in,
   input logic                bus_req,
   input logic                bus_we,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                busy,
   input logic                done
);
   assert_start_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(insn_done));

   assert_first_push_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_req) |-> bus_we && bus_wdata == $past(pc_in[2*DATA_W-1:DATA_W])
                         && bus_addr[SP_W-1:0] == $past(sp_in));

   assert_push_dec_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_req && bus_we && $past(bus_req && bus_we))
      |-> bus_addr[SP_W-1:0] == $past(bus_addr[SP_W-1:0]) - 1'b1);

   assert_vec_base_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_req && !bus_we && $past(bus_req && bus_we))
      |-> (bus_addr == ADDR_W'(VEC_EMU) || bus_addr == ADDR_W'(VEC_NAT)));

   assert_vec_next_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_req && !bus_we && $past(bus_req && !bus_we))
      |-> bus_addr == $past(bus_addr) + 1'b1);

   assert_done_after_read_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(bus_req && !bus_we) && !busy);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_end_done_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done);
endmodule

bind nmi_entry_seq nmi_entry_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W),
   .VEC_EMU(VEC_EMU), .VEC_NAT(VEC_NAT)
) u_chk (
   .clk(clk), .rst(rst), .insn_done(insn_done), .pc_in(pc_in), .sp_in(sp_in),
   .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .busy(busy), .done(done)
);

// File: tb/sim_nmi_entry_seq.sv
module sim_nmi_entry_seq;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        nmi_n = 1'b1;
   logic        emu_mode = 1'b0;
   logic        insn_done = 1'b0;
   logic [15:0] pc_in = '0;
   logic [7:0]  status_in = '0;
   logic [15:0] sp_in = '0;
   logic [7:0]  bus_rdata = '0;
   logic        bus_req, bus_we, busy, done;
   logic [23:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic [15:0] new_pc, sp_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   nmi_entry_seq u0 (.*);

   always #4 clk = ~clk;

   function automatic logic [23:0] vec_base(input logic emu);
      return emu ? 24'h00FFFA : 24'h00FFEA;
   endfunction

   function automatic logic [15:0] sp_less(input logic [15:0] sp, input int k);
      return sp - 16'(k);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_idle(input string req, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk(!busy && !bus_req, req, "stays idle", {busy, bus_req}, 0);
      end
   endtask

   task automatic fire();
      nmi_n = 1'b0;
      @(negedge clk);
      nmi_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_seq(input logic [15:0] pc, input logic [7:0] ps,
                          input logic [15:0] sp, input logic emu,
                          input logic [7:0] lo, input logic [7:0] hi,
                          input bit inject);
      pc_in = pc; status_in = ps; sp_in = sp; emu_mode = emu;
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
      pc_in = ~pc; status_in = ~ps; sp_in = ~sp; emu_mode = ~emu;
      chk(busy && bus_req && bus_we, "R1", "start", {busy, bus_req, bus_we}, 3'b111);
      chk(bus_addr == {8'h00, sp} && bus_wdata == pc[15:8], "R4", "push pc hi",
          {bus_addr, bus_wdata}, {8'h00, sp, pc[15:8]});
      if (inject) nmi_n = 1'b0;
      @(negedge clk);
      if (inject) nmi_n = 1'b1;
      chk(bus_we && bus_addr == {8'h00, sp_less(sp, 1)} && bus_wdata == pc[7:0], "R4",
          "push pc lo", {bus_addr, bus_wdata}, {8'h00, sp_less(sp, 1), pc[7:0]});
      @(negedge clk);
      chk(bus_we && bus_addr == {8'h00, sp_less(sp, 2)} && bus_wdata == ps, "R4",
          "push status", {bus_addr, bus_wdata}, {8'h00, sp_less(sp, 2), ps});
      @(negedge clk);
      bus_rdata = lo;
      chk(bus_req && !bus_we && bus_addr == vec_base(emu), "R5", "vector lo read",
          {bus_we, bus_addr}, {1'b0, vec_base(emu)});
      @(negedge clk);
      bus_rdata = hi;
      chk(bus_req && !bus_we && bus_addr == (vec_base(emu) | 24'h1), "R5", "vector hi read",
          {bus_we, bus_addr}, {1'b0, vec_base(emu) | 24'h1});
      @(negedge clk);
      bus_rdata = 8'h00;
      chk(done && !busy && !bus_req, "R9", "end of bus cycles", {done, busy, bus_req}, 3'b100);
      chk(new_pc == {hi, lo}, "R6", "new pc", new_pc, {hi, lo});
      chk(sp_out == sp_less(sp, 3), "R6", "final sp", sp_out, sp_less(sp, 3));
      @(negedge clk);
      chk(!done, "R6", "done one cycle", done, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy && !bus_req && !done, "R7", "reset state", {busy, bus_req, done}, 0);
      rst = 1'b0;
      @(negedge clk);

      // R1 / R8: glitch edge then boundary strobe
      fire();
      run_seq(16'h1234, 8'hA5, 16'h01FF, 1'b1, 8'h78, 8'h56, 1'b0);

      // R3: pending but no boundary strobe
      fire();
      chk_idle("R3", 4);
      run_seq(16'hBEEF, 8'h3C, 16'h0150, 1'b0, 8'h11, 8'h22, 1'b0);

      // R4 / R6: stack pointer wrap
      fire();
      run_seq(16'h8001, 8'h00, 16'h0001, 1'b0, 8'hFF, 8'h80, 1'b0);

      // R3: edge during a sequence held and taken later
      fire();
      run_seq(16'h4000, 8'h81, 16'h0100, 1'b1, 8'h01, 8'h02, 1'b1);
      chk_idle("R3", 3);
      run_seq(16'h5000, 8'h42, 16'h00FF, 1'b0, 8'h03, 8'h04, 1'b0);
      insn_done = 1'b1;
      chk_idle("R3", 2);
      insn_done = 1'b0;

      // R2: level held low produces one request only
      nmi_n = 1'b0;
      @(negedge clk);
      run_seq(16'h2222, 8'h44, 16'h0180, 1'b1, 8'hAA, 8'hBB, 1'b0);
      insn_done = 1'b1;
      chk_idle("R2", 6);
      insn_done = 1'b0;
      nmi_n = 1'b1;
      @(negedge clk);

      // R7: reset clears a pending request
      fire();
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      insn_done = 1'b1;
      chk_idle("R7", 3);
      insn_done = 1'b0;

      // random entries
      for (int k = 0; k < 40; k++) begin
         logic [15:0] rpc;
         logic [15:0] rsp;
         logic [7:0]  rps, rlo, rhi;
         logic        remu;
         rpc = 16'($urandom); rsp = 16'($urandom); rps = 8'($urandom);
         rlo = 8'($urandom); rhi = 8'($urandom); remu = 1'($urandom);
         fire();
         repeat ($urandom_range(0, 3)) @(negedge clk);
         run_seq(rpc, rps, rsp, remu, rlo, rhi, 1'b0);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule